// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

This block is the master side of a small serial EEPROM link. It drives an active-low chip select, a serial clock and a command/address data line, and samples the data line that comes back. A host supplies a starting byte address and a byte count, then pulses start. The sequencer runs one complete framed read per byte: chip select falls, the read command and the address go out, eight data bits come back, and chip select rises again. The address then moves up by one for the next byte, wrapping at the top of the address space.

Every received byte appears on the read data output for one cycle, qualified by a valid strobe. A one-cycle done pulse closes the run. The host can also request the memory's status byte, which comes back through the same data output. After reset the block runs a wake-up preamble by itself: two serial clock pulses with chip select held high. Only then does it accept commands.

The serial clock half-period is a parameter counted in system clock cycles. Each level of the serial clock inside a transaction lasts exactly that long. The same interval separates two transactions, with chip select high.

Top module: `eeprom_rd_seq`

## Requirements
- R1: After reset, `mem_cs_n` is 1, `busy` is 1, and `done` and `rd_valid` are 0. While `mem_cs_n` stays 1, exactly two rising edges of `mem_sck` occur, and only after them does `busy` fall.
- R2: `mem_sck` is 0 whenever `mem_cs_n` changes. A read transaction holds `mem_cs_n` low across exactly 24 rising edges of `mem_sck`.
- R3: `mem_sdo` changes only while `mem_sck` is 0. A read transaction sends the command 8'h03 MSB first, followed by the 8-bit address MSB first, on the first 16 rising edges.
- R4: A start with `stat_req`=1 runs one transaction. It sends command 8'h05 MSB first on 8 rising edges, then 8 more clock pulses return the status byte, which appears once on `rd_data` with `rd_valid`.
- R5: Each received byte is built MSB first from `mem_sdi`, sampled at the end of the clock-low half just before each receive-phase rising edge.
- R6: A read of N bytes (1 to 2^CNT_W-1) from address A runs N transactions at addresses A, A+1, ... modulo 256.
- R7: Between two transactions `mem_cs_n` stays high for at least HALF_P system clocks.
- R8: Inside a transaction, every level of `mem_sck` lasts exactly HALF_P system clocks, including the low level after `mem_cs_n` falls and the last high level before it rises.
- R9: A start while `busy` is 1 has no effect on the addresses, the number of transactions or the bytes returned.
- R10: `done` pulses for one cycle after the last byte of a run, with `busy` 0 in that cycle. A read with `byte_count`=0 gives `done` without any transaction.
- R11: `rd_valid` is a one-cycle strobe, given exactly once per byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| stat_req | input | 1 | With start: read the status byte instead of data |
| start_addr | input | ADDR_W | First byte address of a data run |
| byte_count | input | CNT_W | Number of data bytes to read |
| busy | output | 1 | Preamble or run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_sck | output | 1 | Memory serial clock |
| mem_sdo | output | 1 | Command and address bits to the memory |
| mem_sdi | input | 1 | Data bits from the memory |

## Verification
The bench targets runs that start near the top of the address space. A design that carried the address into a ninth bit, or failed to wrap it, would fetch the wrong bytes after 0xFF. It pokes start in the middle of a run. A design that accepted that start would run an extra transaction or change its address. It also covers a zero-length read, which would either hang or emit a stray transaction, and a status read, whose shorter frame would come back misaligned if the receive window were counted from the read frame length. Throughout, a behavioural memory model measures each clock level and each chip-select gap. An off-by-one in the half-period counter, or data sampled on the wrong edge, shows up as a bad bit or a bad length.

// File: rtl/eep_rd_pkg.sv
package eep_rd_pkg;
  typedef enum logic [1:0] {K_INIT, K_READ, K_STAT} kind_t;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_STAT = 8'h05;
endpackage

// File: rtl/eep_half_tick.sv
module eep_half_tick #(
  parameter int HALF_P = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_P + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)                cnt <= '0;
    else if (cnt == CW'(HALF_P - 1)) cnt <= '0;
    else                            cnt <= cnt + CW'(1);
  end

  assign tick = run && (cnt == CW'(HALF_P - 1));

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt < CW'(HALF_P));
endmodule

// File: rtl/eep_frame_eng.sv
module eep_frame_eng
  import eep_rd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  kind_t             kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              tick,
  input  logic              miso,
  output logic              active,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  output logic [7:0]        rx_byte,
  output logic              rx_stb,
  output logic              fin
);
  localparam int TX_W = 8 + ADDR_W;
  localparam int PH_N = 2 * (TX_W + 8);
  localparam int PH_W = $clog2(PH_N);

  typedef enum logic [1:0] {E_IDLE, E_ACT, E_GAP} est_t;
  est_t            st;
  kind_t           kind_r;
  logic [PH_W-1:0] ph, last_ph, send_bits;
  logic [TX_W-1:0] tx;
  logic [7:0]      rx;

  assign active = (st != E_IDLE);

  always_ff @(posedge clk) begin
    rx_stb <= 1'b0;
    fin    <= 1'b0;
    if (rst) begin
      st <= E_IDLE; kind_r <= K_INIT; ph <= '0; last_ph <= '0; send_bits <= '0;
      tx <= '0; rx <= '0; cs_n <= 1'b1; sck <= 1'b0; mosi <= 1'b0; rx_byte <= '0;
    end else begin
      case (st)
        E_IDLE: if (go) begin
          st <= E_ACT; kind_r <= kind; ph <= '0; mosi <= 1'b0;
          case (kind)
            K_READ: begin
              last_ph <= PH_W'(PH_N - 1); send_bits <= PH_W'(TX_W);
              tx <= {OP_READ, addr}; cs_n <= 1'b0; sck <= 1'b0;
            end
            K_STAT: begin
              last_ph <= PH_W'(31); send_bits <= PH_W'(8);
              tx <= {OP_STAT, {ADDR_W{1'b0}}}; cs_n <= 1'b0; sck <= 1'b0;
            end
            default: begin
              last_ph <= PH_W'(3); send_bits <= '0;
              tx <= '0; cs_n <= 1'b1; sck <= 1'b1;
            end
          endcase
        end
        E_ACT: if (tick) begin
          if (ph == last_ph) begin
            st <= E_GAP; cs_n <= 1'b1; sck <= 1'b0; mosi <= 1'b0;
            if (kind_r != K_INIT) begin
              rx_byte <= rx; rx_stb <= 1'b1;
            end
          end else begin
            ph  <= ph + PH_W'(1);
            sck <= (kind_r == K_INIT) ? ph[0] : ~ph[0];
            if (!ph[0] && kind_r != K_INIT && {1'b0, ph[PH_W-1:1]} >= send_bits)
              rx <= {rx[6:0], miso};
            if (ph[0]) begin
              tx   <= tx << 1;
              mosi <= tx[TX_W-2];
            end
          end
        end
        default: if (tick) begin
          st <= E_IDLE; fin <= 1'b1;
        end
      endcase
    end
  end

  // R2
  cs_fall_low_sck_chk: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> !sck);
  // R2
  cs_rise_low_sck_chk: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> !sck);
  // R3
  mosi_move_low_chk: assert property (@(posedge clk) disable iff (rst) !$stable(mosi) |-> !sck);
  // R11
  rx_stb_single_chk: assert property (@(posedge clk) disable iff (rst) rx_stb |=> !rx_stb);
endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
  import eep_rd_pkg::*;
#(
  parameter int HALF_P = 5,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stat_req,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              mem_cs_n,
  output logic              mem_sck,
  output logic              mem_sdo,
  input  logic              mem_sdi
);
  typedef enum logic [1:0] {T_BOOT, T_WAIT, T_IDLE} tst_t;
  tst_t              tst;
  kind_t             kind;
  logic              go, eng_active, eng_fin, tick;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  left;

  eep_half_tick #(.HALF_P(HALF_P)) tick_i (
    .clk(clk), .rst(rst), .run(eng_active), .tick(tick)
  );

  eep_frame_eng #(.ADDR_W(ADDR_W)) eng_i (
    .clk(clk), .rst(rst), .go(go), .kind(kind), .addr(cur_addr), .tick(tick),
    .miso(mem_sdi), .active(eng_active), .cs_n(mem_cs_n), .sck(mem_sck),
    .mosi(mem_sdo), .rx_byte(rd_data), .rx_stb(rd_valid), .fin(eng_fin)
  );

  always_ff @(posedge clk) begin
    go   <= 1'b0;
    done <= 1'b0;
    if (rst) begin
      tst <= T_BOOT; kind <= K_INIT; cur_addr <= '0; left <= '0; busy <= 1'b1;
    end else begin
      case (tst)
        T_BOOT: begin
          go <= 1'b1; kind <= K_INIT; tst <= T_WAIT;
        end
        T_WAIT: if (eng_fin) begin
          if (kind == K_INIT) begin
            tst <= T_IDLE; busy <= 1'b0;
          end else if (kind == K_STAT || left == CNT_W'(1)) begin
            tst <= T_IDLE; busy <= 1'b0; done <= 1'b1;
          end else begin
            left     <= left - CNT_W'(1);
            cur_addr <= cur_addr + ADDR_W'(1);
            go       <= 1'b1;
          end
        end
        default: if (start) begin
          if (stat_req) begin
            kind <= K_STAT; go <= 1'b1; busy <= 1'b1; tst <= T_WAIT;
          end else if (byte_count == '0) begin
            done <= 1'b1;
          end else begin
            kind <= K_READ; cur_addr <= start_addr; left <= byte_count;
            go <= 1'b1; busy <= 1'b1; tst <= T_WAIT;
          end
        end
      endcase
    end
  end

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !eng_fin) |=> $stable(cur_addr));
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tst == T_WAIT && eng_fin && kind == K_READ && left != CNT_W'(1))
      |=> cur_addr == $past(cur_addr) + ADDR_W'(1));
endmodule

// File: tb/eeprom_rd_seq_tb_top.sv
module eeprom_rd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_P = 5;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 8;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, stat_req = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0]  byte_count = '0;
  logic busy, done, rd_valid, mem_cs_n, mem_sck, mem_sdo, mem_sdi;
  logic [7:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_rd_seq #(.HALF_P(HALF_P), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .stat_req(stat_req), .start_addr(start_addr),
    .byte_count(byte_count), .busy(busy), .done(done), .rd_data(rd_data),
    .rd_valid(rd_valid), .mem_cs_n(mem_cs_n), .mem_sck(mem_sck), .mem_sdo(mem_sdo),
    .mem_sdi(mem_sdi)
  );

  int nchk = 0, nfail = 0;
  logic [7:0] rom_img [256];
  logic [7:0] stat_val;

  // memory model and monitors, all sampled on the falling system clock edge
  logic cs_prev = 1'b1, sck_prev = 1'b0, done_prev = 1'b0, sdi_r = 1'b0, seen_rise = 1'b0;
  int rcnt = 0, seglen = 0, gap_cnt = 0, init_rises = 0;
  int err_len = 0, err_gap = 0, err_done = 0;
  logic [7:0] opc = '0, adr_sh = '0;
  int ntr = 0, ncap = 0, ndone = 0;
  int tr_op [64], tr_addr [64], tr_bits [64];
  int cap [64];
  assign mem_sdi = sdi_r;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_cs_n != cs_prev || mem_sck != sck_prev) begin
        if (!cs_prev && seglen != HALF_P) err_len++;   // R8
        seglen = 1;
      end else seglen++;
      if (!mem_cs_n && cs_prev) begin
        if (seen_rise && gap_cnt < HALF_P) err_gap++;  // R7
        rcnt = 0;
      end
      if (mem_cs_n && !cs_prev) begin
        if (ntr < 64) begin
          tr_op[ntr] = int'(opc); tr_addr[ntr] = int'(adr_sh); tr_bits[ntr] = rcnt;
        end
        ntr++; gap_cnt = 0; seen_rise = 1'b1;
      end
      if (mem_cs_n) begin
        gap_cnt++;
        if (mem_sck && !sck_prev) init_rises++;
      end else begin
        if (mem_sck && !sck_prev) begin
          if (rcnt < 8) opc = {opc[6:0], mem_sdo};
          else if (rcnt < 16) adr_sh = {adr_sh[6:0], mem_sdo};
          rcnt++;
        end
        if (!mem_sck && sck_prev) begin
          if (opc == 8'h03 && rcnt >= 16 && rcnt < 24) sdi_r = rom_img[adr_sh][23-rcnt];
          else if (opc == 8'h05 && rcnt >= 8 && rcnt < 16) sdi_r = stat_val[15-rcnt];
        end
      end
      if (rd_valid) begin
        if (ncap < 64) cap[ncap] = int'(rd_data);
        ncap++;
      end
      if (done) ndone++;
      if (done && done_prev) err_done++;
    end
    cs_prev = mem_cs_n; sck_prev = mem_sck; done_prev = done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    ntr = 0; ncap = 0; ndone = 0;
  endtask

  task automatic wait_done(input int limit);
    int k = 0;
    while (!done && k < limit) begin
      @(negedge clk); k++;
    end
    chk(done == 1'b1, "R10 done seen", int'(done), 1);
    chk(busy == 1'b0, "R10 busy low with done", int'(busy), 0);
  endtask

  task automatic pulse_start(input bit st, input logic [7:0] a, input int n);
    @(negedge clk);
    stat_req = st; start_addr = a; byte_count = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0; stat_req = 1'b0;
  endtask

  task automatic run_read(input logic [7:0] a, input int n, input bit poke);
    while (busy) @(negedge clk);
    clear_logs();
    pulse_start(1'b0, a, n);
    if (poke) begin
      repeat (100) @(negedge clk);
      pulse_start(1'b1, a ^ 8'h55, 3);   // R9 start while busy
    end
    wait_done(400 * (n + 2));
    repeat (4 * HALF_P) @(negedge clk);
    chk(ntr == n, "R6 transaction count", ntr, n);
    chk(ncap == n, "R11 rd_valid count", ncap, n);
    chk(ndone == 1, "R10 done pulses", ndone, 1);
    for (int i = 0; i < n && i < 64; i++) begin
      int ea = (int'(a) + i) % 256;
      chk(tr_addr[i] == ea, "R6 address", tr_addr[i], ea);
      chk(tr_op[i] == 3, "R3 read opcode", tr_op[i], 3);
      chk(tr_bits[i] == 24, "R2 read clock count", tr_bits[i], 24);
      chk(cap[i] == int'(rom_img[ea]), "R5 data byte", cap[i], int'(rom_img[ea]));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) rom_img[i] = 8'($urandom);
    stat_val = 8'hA6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_cs_n == 1'b1, "R1 reset cs_n", int'(mem_cs_n), 1);
    chk(busy == 1'b1, "R1 reset busy", int'(busy), 1);
    chk(done == 1'b0 && rd_valid == 1'b0, "R1 reset done/valid", int'(done), 0);
    while (busy) @(negedge clk);
    chk(init_rises == 2, "R1 preamble rising edges", init_rises, 2);
    chk(ntr == 0, "R1 no framed transaction in preamble", ntr, 0);

    run_read(8'h10, 1, 1'b0);
    run_read(8'hFE, 4, 1'b0);          // wrap past top
    run_read(8'h3C, 4, 1'b1);          // start poked while busy

    // R4 status read
    while (busy) @(negedge clk);
    clear_logs();
    pulse_start(1'b1, 8'h00, 0);
    wait_done(600);
    repeat (4 * HALF_P) @(negedge clk);
    chk(ntr == 1, "R4 status transactions", ntr, 1);
    chk(tr_op[0] == 5, "R4 status opcode", tr_op[0], 5);
    chk(tr_bits[0] == 16, "R4 status clock count", tr_bits[0], 16);
    chk(ncap == 1 && cap[0] == int'(stat_val), "R4 status value", cap[0], int'(stat_val));

    // R10 zero-length read
    clear_logs();
    pulse_start(1'b0, 8'h20, 0);
    repeat (3) @(negedge clk);
    chk(ndone == 1, "R10 zero count done", ndone, 1);
    repeat (4 * HALF_P) @(negedge clk);
    chk(ntr == 0 && ncap == 0, "R10 zero count no transaction", ntr, 0);

    for (int t = 0; t < 8; t++)
      run_read(8'($urandom), 1 + int'($urandom % 6), 1'b0);

    chk(err_len == 0, "R8 clock level length errors", err_len, 0);
    chk(err_gap == 0, "R7 chip select gap errors", err_gap, 0);
    chk(err_done == 0, "R10 done width errors", err_done, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule